// File: doc/BRIEF.md
# Stop Mode Power Controller

This block sequences a small microcontroller into and out of its deepest low-power state. A one-cycle stop request, standing in for the stop instruction, is checked against the current configuration. If the configuration is safe, the controller turns off both oscillator enables, parks the gated system clock at logic high and halts the CPU. Peripherals that run from an external count source or an external clock keep running. Internally clocked peripherals are frozen with their state kept. On the same entry edge, the block issues one-cycle write-back strobes that clear selected bits of the timer mode register and the clock control register.

Stop mode ends on a synchronous reset or on an accepted wake interrupt. After a wake, the oscillator enables return first. A settling counter of `SETTLE_CYCLES` cycles (512 by default) must then expire before the clock is released, the CPU halt drops and the accepted wake sources are forwarded. A reset at any point aborts the sequence and returns the controller to the run state.

Top module: `stop_sequencer`

## Requirements
- R1: A stop request in RUN with a valid configuration moves the state to STOP on the next cycle. In STOP, `osc_main_en` and `osc_sub_en` are 0 and `cpu_halt` is 1. The state encoding is RUN=0, STOP=1, SETTLE=2.
- R2: `sysclk_o` follows `phi_i` in RUN and is held at 1 in both STOP and SETTLE.
- R3: A wake source i is accepted only when three conditions hold: its `wake_en` bit was 1 at stop entry, its `wake_req` bit was 0 at stop entry, and `irq_disable` is 0 when it fires. A request that is not accepted leaves the state in STOP.
- R4: An accepted wake moves the state to SETTLE. In SETTLE both oscillator enables are 1 and `cpu_halt` stays 1 for exactly `SETTLE_CYCLES` cycles. After that the state returns to RUN, and `wake_fwd` pulses for one cycle with the accepted sources.
- R5: On stop entry, `tmode_we` pulses for one cycle. The accompanying `tmode_wd` equals the sampled timer mode value with every bit except bit 4 cleared.
- R6: On stop entry, `clkctl_we` pulses for one cycle. The accompanying `clkctl_wd` equals the sampled clock control value with bit 7 cleared, which selects main clock divided by 2.
- R7: `per_run_en` is all ones in RUN. In STOP and SETTLE it equals the `per_ext` pattern sampled at entry.
- R8: A stop request made while any of the timer 1 or timer 2 interrupt enable or request bits is set is refused. The state stays RUN and `err_o` bit 1 pulses for one cycle.
- R9: A stop request made while `clk_syn_sel` is 1 is refused. The state stays RUN and `err_o` bit 0 pulses for one cycle.
- R10: A reset in any state returns the controller to RUN on the next cycle with both oscillators enabled, `cpu_halt` at 0 and no transition pulse.
- R11: `trans_o` pulses for exactly one cycle after every state change that is not caused by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| phi_i | input | 1 | Ungated internal system clock |
| stop_req | input | 1 | One-cycle stop request |
| wake_req | input | NWAKE | Wake interrupt request lines |
| wake_en | input | NWAKE | Wake interrupt enable bits |
| irq_disable | input | 1 | Global interrupt-disable flag |
| t1_ie | input | 1 | Timer 1 interrupt enable |
| t2_ie | input | 1 | Timer 2 interrupt enable |
| t1_rq | input | 1 | Timer 1 interrupt request |
| t2_rq | input | 1 | Timer 2 interrupt request |
| clk_syn_sel | input | 1 | Synthesized clock selected as system clock |
| tmode_i | input | 8 | Live timer mode register |
| clkctl_i | input | 8 | Live clock control register |
| per_ext | input | NPER | Peripheral uses an external clock or count source |
| osc_main_en | output | 1 | Main oscillator enable |
| osc_sub_en | output | 1 | Sub oscillator enable |
| sysclk_o | output | 1 | Gated system clock, parked high while stopped |
| cpu_halt | output | 1 | CPU halt |
| per_run_en | output | NPER | Peripheral run enables |
| tmode_we | output | 1 | Timer mode write-back strobe |
| tmode_wd | output | 8 | Timer mode write-back data |
| clkctl_we | output | 1 | Clock control write-back strobe |
| clkctl_wd | output | 8 | Clock control write-back data |
| wake_fwd | output | NWAKE | Accepted wake sources, pulsed at release |
| err_o | output | 2 | Refusal pulse: bit 1 timer 1/2 setup, bit 0 synthesized clock |
| trans_o | output | 1 | State change pulse |
| state_o | output | 2 | Current state |

## Verification
The wake sweep covers every source index. For each index it tries every combination of enable bit, request bit pending at entry, and global disable flag. This separates the one accepted pattern from the three ways a wake can be rejected. It also confirms that only the fired source is forwarded after exactly the settling count. The refusal sweep runs all 32 combinations of the four timer 1/2 bits and the synthesized-clock select, so each error bit is seen alone, together with the other, and absent. The register write-back data and the peripheral pattern change from episode to episode, which exposes a wrong kept-bit or cleared-bit mask. Resets issued in STOP and midway through SETTLE show that both states abort straight to RUN without a transition pulse.

// File: rtl/stop_seq_pkg.sv
package stop_seq_pkg;
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_STOP   = 2'd1,
        ST_SETTLE = 2'd2
    } seq_state_e;

    localparam int REG_W        = 8;
    localparam int TMODE_KEEP   = 4;
    localparam int CLK_DIV_BIT  = 7;
    localparam int ERR_SYN_BIT  = 0;
    localparam int ERR_TMR_BIT  = 1;
endpackage

// File: rtl/wake_gate.sv
module wake_gate #(
    parameter int NWAKE = 8
) (
    input  logic [NWAKE-1:0] armed,
    input  logic [NWAKE-1:0] req,
    input  logic             irq_disable,
    output logic [NWAKE-1:0] hits,
    output logic             any_hit
);
    always_comb begin
        hits    = irq_disable ? '0 : (armed & req);
        any_hit = |hits;
    end
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
    parameter int SETTLE_CYCLES = 512
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);
    localparam int CW = (SETTLE_CYCLES > 2) ? $clog2(SETTLE_CYCLES) : 1;
    localparam logic [CW-1:0] LOAD_VAL = CW'(SETTLE_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = LOAD_VAL;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst) cnt_q <= LOAD_VAL); // R4
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst) (!load && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1); // R4
endmodule

// File: rtl/stop_sequencer.sv
module stop_sequencer
    import stop_seq_pkg::*;
#(
    parameter int NWAKE         = 8,
    parameter int NPER          = 4,
    parameter int SETTLE_CYCLES = 512
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               phi_i,
    input  logic               stop_req,
    input  logic [NWAKE-1:0]   wake_req,
    input  logic [NWAKE-1:0]   wake_en,
    input  logic               irq_disable,
    input  logic               t1_ie,
    input  logic               t2_ie,
    input  logic               t1_rq,
    input  logic               t2_rq,
    input  logic               clk_syn_sel,
    input  logic [REG_W-1:0]   tmode_i,
    input  logic [REG_W-1:0]   clkctl_i,
    input  logic [NPER-1:0]    per_ext,
    output logic               osc_main_en,
    output logic               osc_sub_en,
    output logic               sysclk_o,
    output logic               cpu_halt,
    output logic [NPER-1:0]    per_run_en,
    output logic               tmode_we,
    output logic [REG_W-1:0]   tmode_wd,
    output logic               clkctl_we,
    output logic [REG_W-1:0]   clkctl_wd,
    output logic [NWAKE-1:0]   wake_fwd,
    output logic [1:0]         err_o,
    output logic               trans_o,
    output logic [1:0]         state_o
);
    localparam logic [REG_W-1:0] KEEP_MASK = REG_W'(1) << TMODE_KEEP;
    localparam logic [REG_W-1:0] DIV_MASK  = REG_W'(1) << CLK_DIV_BIT;

    typedef struct packed {
        seq_state_e        st;
        logic [NWAKE-1:0]  armed;
        logic [NWAKE-1:0]  woke;
        logic [NPER-1:0]   ext;
        logic              tm_we;
        logic [REG_W-1:0]  tm_d;
        logic              ck_we;
        logic [REG_W-1:0]  ck_d;
        logic [1:0]        err;
        logic              trans;
        logic [NWAKE-1:0]  fwd;
    } seq_regs_t;

    seq_regs_t ctl_d, ctl_q;

    logic [NWAKE-1:0] hits;
    logic             hit_any;
    logic             settle_load;
    logic             settle_done;
    logic             tmr_bad;

    wake_gate #(.NWAKE(NWAKE)) i_wake_gate (
        .armed       (ctl_q.armed),
        .req         (wake_req),
        .irq_disable (irq_disable),
        .hits        (hits),
        .any_hit     (hit_any)
    );

    assign settle_load = (ctl_q.st == ST_STOP) && hit_any;

    settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) i_settle_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (settle_load),
        .expired (settle_done)
    );

    assign tmr_bad = t1_ie | t2_ie | t1_rq | t2_rq;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.tm_we = 1'b0;
        ctl_d.ck_we = 1'b0;
        ctl_d.err   = '0;
        ctl_d.trans = 1'b0;
        ctl_d.fwd   = '0;
        unique case (ctl_q.st)
            ST_RUN: begin
                if (stop_req) begin
                    if (tmr_bad || clk_syn_sel) begin
                        ctl_d.err[ERR_TMR_BIT] = tmr_bad;
                        ctl_d.err[ERR_SYN_BIT] = clk_syn_sel;
                    end else begin
                        ctl_d.st    = ST_STOP;
                        ctl_d.trans = 1'b1;
                        ctl_d.armed = wake_en & ~wake_req;
                        ctl_d.ext   = per_ext;
                        ctl_d.tm_we = 1'b1;
                        ctl_d.tm_d  = tmode_i & KEEP_MASK;
                        ctl_d.ck_we = 1'b1;
                        ctl_d.ck_d  = clkctl_i & ~DIV_MASK;
                    end
                end
            end
            ST_STOP: begin
                if (hit_any) begin
                    ctl_d.st    = ST_SETTLE;
                    ctl_d.trans = 1'b1;
                    ctl_d.woke  = hits;
                end
            end
            ST_SETTLE: begin
                if (settle_done) begin
                    ctl_d.st    = ST_RUN;
                    ctl_d.trans = 1'b1;
                    ctl_d.fwd   = ctl_q.woke;
                end
            end
            default: ctl_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '{st: ST_RUN, default: '0};
        else     ctl_q <= ctl_d;
    end

    assign osc_main_en = (ctl_q.st != ST_STOP);
    assign osc_sub_en  = (ctl_q.st != ST_STOP);
    assign cpu_halt    = (ctl_q.st != ST_RUN);
    assign sysclk_o    = phi_i | (ctl_q.st != ST_RUN);
    assign per_run_en  = (ctl_q.st == ST_RUN) ? {NPER{1'b1}} : ctl_q.ext;
    assign tmode_we    = ctl_q.tm_we;
    assign tmode_wd    = ctl_q.tm_d;
    assign clkctl_we   = ctl_q.ck_we;
    assign clkctl_wd   = ctl_q.ck_d;
    assign wake_fwd    = ctl_q.fwd;
    assign err_o       = ctl_q.err;
    assign trans_o     = ctl_q.trans;
    assign state_o     = ctl_q.st;

    AST_ENTRY_MASK: assert property (@(posedge clk) disable iff (rst) (ctl_q.st == ST_RUN && stop_req && !tmr_bad && !clk_syn_sel) |=> (tmode_we && clkctl_we && (tmode_wd & ~KEEP_MASK) == '0 && !clkctl_wd[CLK_DIV_BIT])); // R5
    AST_REFUSE_STAYS: assert property (@(posedge clk) disable iff (rst) (err_o != '0) |-> (state_o == ST_RUN && !cpu_halt && !tmode_we)); // R8
    AST_WAKE_FLAG: assert property (@(posedge clk) disable iff (rst) (ctl_q.st == ST_STOP && hit_any) |-> (!irq_disable && (wake_req & ~ctl_q.armed & hits) == '0)); // R3
    AST_SETTLE_OSC: assert property (@(posedge clk) disable iff (rst) (ctl_q.st == ST_SETTLE) |-> (osc_main_en && osc_sub_en && cpu_halt && sysclk_o)); // R4
    AST_RESET_RUN: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> (state_o == ST_RUN && !trans_o && osc_main_en)); // R10
    AST_FWD_AT_RELEASE: assert property (@(posedge clk) disable iff (rst) (wake_fwd != '0) |-> (state_o == ST_RUN && trans_o)); // R4
endmodule

// File: tb/test_stop_sequencer.sv
module test_stop_sequencer;
    localparam int NW = 4;
    localparam int NP = 3;
    localparam int SC = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic phi_i = 1'b0;
    logic stop_req = 1'b0;
    logic [NW-1:0] wake_req = '0;
    logic [NW-1:0] wake_en = '0;
    logic irq_disable = 1'b0;
    logic t1_ie = 1'b0, t2_ie = 1'b0, t1_rq = 1'b0, t2_rq = 1'b0;
    logic clk_syn_sel = 1'b0;
    logic [7:0] tmode_i = '0, clkctl_i = '0;
    logic [NP-1:0] per_ext = '0;
    logic osc_main_en, osc_sub_en, sysclk_o, cpu_halt;
    logic [NP-1:0] per_run_en;
    logic tmode_we, clkctl_we, trans_o;
    logic [7:0] tmode_wd, clkctl_wd;
    logic [NW-1:0] wake_fwd;
    logic [1:0] err_o, state_o;

    int nchk = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    stop_sequencer #(.NWAKE(NW), .NPER(NP), .SETTLE_CYCLES(SC)) i_stop_sequencer (
        .clk(clk), .rst(rst), .phi_i(phi_i), .stop_req(stop_req),
        .wake_req(wake_req), .wake_en(wake_en), .irq_disable(irq_disable),
        .t1_ie(t1_ie), .t2_ie(t2_ie), .t1_rq(t1_rq), .t2_rq(t2_rq),
        .clk_syn_sel(clk_syn_sel), .tmode_i(tmode_i), .clkctl_i(clkctl_i),
        .per_ext(per_ext), .osc_main_en(osc_main_en), .osc_sub_en(osc_sub_en),
        .sysclk_o(sysclk_o), .cpu_halt(cpu_halt), .per_run_en(per_run_en),
        .tmode_we(tmode_we), .tmode_wd(tmode_wd), .clkctl_we(clkctl_we),
        .clkctl_wd(clkctl_wd), .wake_fwd(wake_fwd), .err_o(err_o),
        .trans_o(trans_o), .state_o(state_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step();
        rst = 1'b0;
        chk("R10 state", 32'(state_o), 0);
        chk("R10 osc", {osc_main_en, osc_sub_en, cpu_halt, trans_o}, 4'b1100);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        step();
        step();
        rst = 1'b0;
        step();
        chk("R10 reset state", 32'(state_o), 0);
        chk("R7 reset run enables", 32'(per_run_en), 3'b111);
        chk("R2 clock follows phi", 32'(sysclk_o), 0);
        phi_i = 1'b1;
        step();
        chk("R2 clock follows phi high", 32'(sysclk_o), 1);
        phi_i = 1'b0;

        // wake sweep: source x enable x pending-at-entry x disable
        for (int idx = 0; idx < NW * 8; idx++) begin
            automatic int s = idx / 8;
            automatic logic e = idx[0];
            automatic logic p = idx[1];
            automatic logic d = idx[2];
            automatic logic acc = e && !p && !d;
            automatic logic [7:0] tv = 8'((idx * 37 + 5) & 255);
            automatic logic [7:0] cv = 8'((idx * 91 + 200) & 255);
            automatic logic [NP-1:0] pe = NP'(idx * 5);
            wake_en = NW'(e) << s;
            wake_req = NW'(p) << s;
            irq_disable = d;
            tmode_i = tv;
            clkctl_i = cv;
            per_ext = pe;
            stop_req = 1'b1;
            step();
            stop_req = 1'b0;
            wake_req = '0;
            per_ext = ~pe;
            chk("R1 enter stop", 32'(state_o), 1);
            chk("R1 osc off halt", {osc_main_en, osc_sub_en, cpu_halt}, 3'b001);
            chk("R2 clock parked", 32'(sysclk_o), 1);
            chk("R5 tmode write", {tmode_we, tmode_wd}, {1'b1, tv & 8'h10});
            chk("R6 clkctl write", {clkctl_we, clkctl_wd}, {1'b1, cv & 8'h7F});
            chk("R7 ext run enables", 32'(per_run_en), 32'(pe));
            chk("R11 entry pulse", 32'(trans_o), 1);
            step();
            chk("R5 strobe single", {tmode_we, clkctl_we, trans_o}, 3'b000);
            wake_req = NW'(1) << s;
            step();
            wake_req = '0;
            if (acc) begin
                chk("R3 accepted", 32'(state_o), 2);
                chk("R4 osc back", {osc_main_en, osc_sub_en, cpu_halt, sysclk_o}, 4'b1111);
                chk("R11 settle pulse", 32'(trans_o), 1);
                repeat (SC - 1) step();
                chk("R4 still settling", {32'(state_o), 1'b0}, {32'd2, 1'b0});
                chk("R7 frozen while settling", 32'(per_run_en), 32'(pe));
                step();
                chk("R4 released", {state_o, cpu_halt}, 3'b000);
                chk("R4 forwarded", 32'(wake_fwd), 32'(NW'(1) << s));
                chk("R11 release pulse", 32'(trans_o), 1);
                step();
                chk("R4 forward single", {wake_fwd, trans_o}, '0);
            end else begin
                chk("R3 rejected", {32'(state_o), trans_o}, {32'd1, 1'b0});
                step();
                chk("R3 still stopped", 32'(state_o), 1);
                do_reset();
            end
        end

        // refusal sweep over timer 1/2 bits and synthesized-clock select
        for (int c = 0; c < 32; c++) begin
            automatic logic tb = |c[3:0];
            automatic logic sy = c[4];
            {t1_ie, t2_ie, t1_rq, t2_rq} = c[3:0];
            clk_syn_sel = sy;
            wake_en = '1;
            irq_disable = 1'b0;
            stop_req = 1'b1;
            step();
            stop_req = 1'b0;
            chk("R8 R9 error bits", 32'(err_o), {30'd0, tb, sy});
            if (tb || sy) begin
                chk("R8 stays run", {32'(state_o), cpu_halt, tmode_we}, {32'd0, 2'b00});
                step();
                chk("R9 error single", 32'(err_o), 0);
            end else begin
                chk("R1 valid entry", 32'(state_o), 1);
                do_reset();
            end
        end
        {t1_ie, t2_ie, t1_rq, t2_rq, clk_syn_sel} = '0;

        // reset abort mid-settle
        wake_en = 4'b0010;
        stop_req = 1'b1;
        step();
        stop_req = 1'b0;
        wake_req = 4'b0010;
        step();
        wake_req = '0;
        chk("R4 settle before abort", 32'(state_o), 2);
        step();
        do_reset();
        chk("R10 abort no forward", 32'(wake_fwd), 0);
        step();
        chk("R10 stays run", 32'(state_o), 0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule